// File: doc/BRIEF.md
# Asynchronous Word-Memory Read Sequencer

This block lets a synchronous host fetch 16-bit words from a 64K-word asynchronous read-only memory that has an address bus, an active-low chip select and an active-low output gate. The host presents a word address together with a one-cycle request. The sequencer latches the address onto the memory pins and selects the chip in the same clock edge. It then opens the output gate as late as it can without lengthening the access. When the access window has elapsed it captures the data word and returns it with a one-cycle valid strobe.

After capture, the sequencer releases both control lines together. It then keeps `req_ready` low for the bus float window, so that no other driver is turned on while the memory outputs are still draining. All waits come from nanosecond parameters and the clock period. Each wait is rounded up to whole cycles.

The controller has four states. `ST_IDLE` waits for a request with ready high. `ST_LEAD` holds the chip selected with the output gate closed. `ST_STROBE` holds the chip selected with the gate open. `ST_FLOAT` has both lines released and ready low. The transitions are:
- IDLE→LEAD when a request is accepted and the lead time is not zero.
- IDLE→STROBE when a request is accepted and the lead time is zero.
- LEAD→STROBE when the lead wait ends.
- STROBE→FLOAT when the access ends; the data is captured on this edge.
- FLOAT→IDLE when the float wait ends.

Top module: `async_mem_rd_ctrl`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_oe_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low for ACC_CYC + DF_CYC cycles. A `req_valid` seen while `req_ready` is low is ignored: it starts no access and changes neither the address nor the returned data.
- R3: `mem_addr` takes the accepted address on the accepting edge. It stays stable for as long as `mem_ce_n` is low.
- R4: `mem_ce_n` goes low on the accepting edge and stays low for exactly ACC_CYC cycles. ACC_CYC is the largest of ceil(T_ACC_NS/CLK_NS), ceil(T_CE_NS/CLK_NS) and OE_CYC.
- R5: `mem_oe_n` goes low ACC_CYC − OE_CYC cycles after `mem_ce_n` goes low (at once when that value is zero). It rises on the same edge as `mem_ce_n`. OE_CYC is ceil(T_OE_NS/CLK_NS), with a minimum of 1. `mem_oe_n` is never low while `mem_ce_n` is high.
- R6: `mem_dq_in` is sampled on the edge that releases both control lines. `rsp_valid` is high for exactly the one following cycle. `rsp_data` holds the sampled word until the next response.
- R7: After release, both control lines stay high and `req_ready` stays low for DF_CYC cycles. DF_CYC is ceil(T_DF_NS/CLK_NS), with a minimum of 1. `req_ready` then returns high.
- R8: Every wait is a ceiling division of a nanosecond parameter by CLK_NS, so a non-integer ratio rounds up to the next whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, taken when `req_ready` is high |
| req_addr | input | 16 | Word address of the request |
| req_ready | output | 1 | High when a new request can be taken |
| rsp_valid | output | 1 | One-cycle strobe marking `rsp_data` as new |
| rsp_data | output | 16 | Captured data word |
| mem_addr | output | 16 | Address to the memory |
| mem_ce_n | output | 1 | Chip select to the memory, active low |
| mem_oe_n | output | 1 | Output gate to the memory, active low |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The main instance uses CLK_NS=10 with 55/55/40/30 ns timings. This gives a 6-cycle access with a 2-cycle lead before the output gate opens and a 3-cycle float, which exercises the LEAD state and rounding from 5.5 up to 6 cycles. A second instance uses CLK_NS=20 with T_OE_NS=60, above the access time. Its lead is zero, so it takes the direct IDLE→STROBE transition, and 30 ns rounds up to a 2-cycle float. Each instance reads from a timing-aware memory model that returns a poison word whenever its select or gate has not been held long enough, so a capture taken too early shows up as a data mismatch.

// File: rtl/async_mem_rd_pkg.sv
package async_mem_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_STROBE,
        ST_FLOAT
    } rd_state_t;

    // ceiling division of a nanosecond figure by the clock period
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/word_latch.sv
module word_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/async_mem_rd_ctrl.sv
module async_mem_rd_ctrl
    import async_mem_rd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int CLK_NS   = 10,
    parameter int T_ACC_NS = 55,
    parameter int T_CE_NS  = 55,
    parameter int T_OE_NS  = 40,
    parameter int T_DF_NS  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    input  logic [DW-1:0] mem_dq_in
);

    // derived cycle counts (R8)
    localparam int OE_CYC   = imax(1, ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int ACC_CYC  = imax(imax(ns_to_cyc(T_ACC_NS, CLK_NS),
                                        ns_to_cyc(T_CE_NS, CLK_NS)), OE_CYC);
    localparam int LEAD_CYC = ACC_CYC - OE_CYC;
    localparam int DF_CYC   = imax(1, ns_to_cyc(T_DF_NS, CLK_NS));
    localparam int CW       = $clog2(ACC_CYC + DF_CYC + 1);
    localparam logic [CW-1:0] LEAD_LD = CW'((LEAD_CYC > 0) ? LEAD_CYC - 1 : 0);
    localparam logic [CW-1:0] OE_LD   = CW'(OE_CYC - 1);
    localparam logic [CW-1:0] DF_LD   = CW'(DF_CYC - 1);

    rd_state_t     state_q, state_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          addr_en;
    logic          data_en;
    logic          rsp_q;

    wait_timer #(.W(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    word_latch #(.W(AW)) addr_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (addr_en),
        .d     (req_addr),
        .q     (mem_addr)
    );

    word_latch #(.W(DW)) data_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (data_en),
        .d     (mem_dq_in),
        .q     (rsp_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rsp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rsp_q   <= data_en;
        end
    end

    // next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        addr_en  = 1'b0;
        data_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    addr_en  = 1'b1;
                    tmr_load = 1'b1;
                    if (LEAD_CYC > 0) begin
                        state_d = ST_LEAD;
                        tmr_val = LEAD_LD;
                    end else begin
                        state_d = ST_STROBE;
                        tmr_val = OE_LD;
                    end
                end
            end
            ST_LEAD: begin
                if (tmr_done) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = OE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d  = ST_FLOAT;
                    tmr_load = 1'b1;
                    tmr_val  = DF_LD;
                    data_en  = 1'b1;
                end
            end
            ST_FLOAT: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LEAD:   mem_ce_n  = 1'b0;
            ST_STROBE: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_FLOAT:  ;
        endcase
    end

    assign rsp_valid = rsp_q;

endmodule

// File: rtl/async_mem_rd_ctrl_chk.sv
module async_mem_rd_ctrl_chk #(
    parameter int AW     = 16,
    parameter int DF_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic [AW-1:0] mem_addr
);

    logic [7:0] float_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            float_cnt <= '0;
        end else if (!mem_ce_n) begin
            float_cnt <= '0;
        end else if (!req_ready) begin
            float_cnt <= float_cnt + 1'b1;
        end
    end

    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_ce_n && mem_oe_n && req_ready));

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_accept_selects_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !mem_ce_n);

    p_gate_needs_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    p_lines_release_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> $past(!mem_oe_n));

    p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_ce_n && $past(!mem_ce_n)));

    p_float_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (float_cnt == 8'(DF_CYC)));

endmodule

bind async_mem_rd_ctrl async_mem_rd_ctrl_chk #(
    .AW     (AW),
    .DF_CYC (DF_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr)
);

// File: tb/async_mem_rd_ctrl_tb_top.sv
module tb_mem_model #(
    parameter int ACC = 6,
    parameter int OE  = 4
) (
    input  logic        clk,
    input  logic [15:0] addr,
    input  logic        ce_n,
    input  logic        oe_n,
    output logic [15:0] dq
);
    int ce_cnt = 0;
    int oe_cnt = 0;

    always_ff @(posedge clk) begin
        ce_cnt <= ce_n ? 0 : ce_cnt + 1;
        oe_cnt <= oe_n ? 0 : oe_cnt + 1;
    end

    // valid only if, by the next edge, both windows have been met
    always_comb begin
        if (!ce_n && !oe_n && (ce_cnt + 1 >= ACC) && (oe_cnt + 1 >= OE))
            dq = {addr[7:0], addr[15:8]} ^ 16'h5A3C;
        else
            dq = 16'hDEAD;
    end
endmodule

module async_mem_rd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    // expected cycle counts from the requirement formulas
    localparam int E_ACC  = 6;   // ceil(55/10)
    localparam int E_OE   = 4;   // ceil(40/10)
    localparam int E_LEAD = 2;
    localparam int E_DF   = 3;   // ceil(30/10)
    localparam int Z_ACC  = 3;   // ceil(55/20), ceil(60/20)
    localparam int Z_DF   = 2;   // ceil(30/20)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n;
    logic [15:0] rsp_data, mem_addr, mem_dq;
    logic        z_req_valid = 1'b0;
    logic [15:0] z_req_addr = '0;
    logic        z_ready, z_rsp_valid, z_ce_n, z_oe_n;
    logic [15:0] z_rsp_data, z_addr, z_dq;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_mem_rd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq_in(mem_dq)
    );

    tb_mem_model #(.ACC(E_ACC), .OE(E_OE)) mem_i (
        .clk(clk), .addr(mem_addr), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .dq(mem_dq)
    );

    async_mem_rd_ctrl #(.CLK_NS(20), .T_OE_NS(60)) dut_z (
        .clk(clk), .rst_n(rst_n), .req_valid(z_req_valid), .req_addr(z_req_addr),
        .req_ready(z_ready), .rsp_valid(z_rsp_valid), .rsp_data(z_rsp_data),
        .mem_addr(z_addr), .mem_ce_n(z_ce_n), .mem_oe_n(z_oe_n),
        .mem_dq_in(z_dq)
    );

    tb_mem_model #(.ACC(Z_ACC), .OE(Z_ACC)) mem_z (
        .clk(clk), .addr(z_addr), .ce_n(z_ce_n), .oe_n(z_oe_n), .dq(z_dq)
    );

    function automatic logic [15:0] model_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(mem_ce_n == 1'b1, "R1 ce_n after reset", int'(mem_ce_n), 1);
        check(mem_oe_n == 1'b1, "R1 oe_n after reset", int'(mem_oe_n), 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    endtask

    // one read on dut_i; with busy_poke, a second request is held during the busy window
    task automatic t_read(input logic [15:0] a, input bit busy_poke);
        int ce_low = 0, oe_low = 0, first_oe = -1, rsp_k = -1, rsp_n = 0;
        int rdy_low = 0, addr_bad = 0, float_bad = 0;
        logic [15:0] got = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        if (busy_poke) req_addr = ~a;
        else req_valid = 1'b0;
        for (int k = 0; k <= E_ACC + E_DF; k++) begin
            if (!mem_ce_n) begin
                ce_low++;
                if (mem_addr != a) addr_bad++;
            end
            if (!mem_oe_n) begin
                oe_low++;
                if (first_oe < 0) first_oe = k;
            end
            if (rsp_valid) begin
                rsp_n++;
                rsp_k = k;
                got = rsp_data;
            end
            if (!req_ready) rdy_low++;
            if (k >= E_ACC && k < E_ACC + E_DF && (!mem_ce_n || !mem_oe_n)) float_bad++;
            if (k == E_ACC + E_DF - 1) req_valid = 1'b0;
            @(negedge clk);
        end
        check(ce_low == E_ACC, "R4 ce_n low cycles", ce_low, E_ACC);
        check(first_oe == E_LEAD, "R5 oe_n lead cycles", first_oe, E_LEAD);
        check(oe_low == E_OE, "R5 oe_n low cycles", oe_low, E_OE);
        check(addr_bad == 0, "R3 address held while selected", addr_bad, 0);
        check(rsp_k == E_ACC && rsp_n == 1, "R6 rsp_valid single pulse timing", rsp_k, E_ACC);
        check(got == model_word(a), "R6 returned word", int'(got), int'(model_word(a)));
        check(float_bad == 0, "R7 lines high during float", float_bad, 0);
        check(rdy_low == E_ACC + E_DF, "R2 ready low window", rdy_low, E_ACC + E_DF);
        check(req_ready == 1'b1 && mem_ce_n == 1'b1, "R2 no access from busy request",
              int'(mem_ce_n), 1);
        check(rsp_data == model_word(a), "R6 rsp_data held", int'(rsp_data),
              int'(model_word(a)));
    endtask

    // zero-lead variant: gate opens with select; rounding of 55/20 and 30/20 (R8)
    task automatic t_zero_lead(input logic [15:0] a);
        int first_oe = -1, rsp_k = -1, rdy_low = 0;
        logic [15:0] got = '0;
        while (!z_ready) @(negedge clk);
        z_req_valid = 1'b1;
        z_req_addr  = a;
        @(negedge clk);
        z_req_valid = 1'b0;
        for (int k = 0; k <= Z_ACC + Z_DF; k++) begin
            if (!z_oe_n && first_oe < 0) first_oe = k;
            if (z_rsp_valid) begin
                rsp_k = k;
                got = z_rsp_data;
            end
            if (!z_ready) rdy_low++;
            @(negedge clk);
        end
        check(first_oe == 0, "R5 zero lead opens gate with select", first_oe, 0);
        check(rsp_k == Z_ACC, "R8 rounded access cycles", rsp_k, Z_ACC);
        check(got == model_word(a), "R6 zero lead word", int'(got), int'(model_word(a)));
        check(rdy_low == Z_ACC + Z_DF, "R8 rounded float cycles", rdy_low, Z_ACC + Z_DF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read(16'h0000, 1'b0);
        t_read(16'hFFFF, 1'b0);
        t_read(16'h1234, 1'b1);
        t_read(16'hA55A, 1'b0);
        t_zero_lead(16'h0F0F);
        t_zero_lead(16'hFFFE);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                vectors++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end
endmodule